// File: doc/BRIEF.md
# Carryless Multiply Modulo the CRC-16 Polynomial

This unit takes two 16-bit operands, treats each as a polynomial over GF(2), and returns their product reduced modulo the 17-bit CRC-16 generator x^16 + x^12 + x^5 + 1. Its intended use is a CRC engine that consumes bytes in reverse order. Such an engine keeps a running "zero-padding" multiplier and folds each byte into the checksum through this product. It can also scale a finished checksum by x^(8n), which stands for n appended zero bytes.

The full 31-bit carryless product comes from an AND array whose bit columns are summed by balanced XOR trees. The product is then reduced without any bit-serial division. The upper 15 bits are multiplied by a fixed reciprocal, floor(x^31 / P) = 0x8898, and shifted right by 15. This yields the quotient. The quotient is multiplied by the low 16 bits of P, and that result is XORed onto the low half of the product. An optional register between the product and the reduction gives a two-cycle pipeline that accepts one operation per clock. Without it the latency is one cycle.

Top module: `gf2_mulmod`

## Requirements
- R1: `result` equals the value produced by a bit-serial reference over the same operands. The reference starts from zero and runs 16 iterations, taking `op_b` from its most significant bit down. Each iteration shifts the partial value left one place, XORs in 0x1021 when the bit shifted out is 1, and then XORs in `op_a` when the current bit of `op_b` is 1.
- R2: When both operands are below 0x100, the product is below x^16 and `result` equals the plain carryless product, with no reduction applied.
- R3: For products that reach x^16 or beyond, the reduction folds the upper half back in. For example, 0x0100 times 0x0100 gives 0x1021.
- R4: With the product register present (default), `result` for an operation presented with `in_valid` high appears exactly two clock edges later. A new operation may be presented on every cycle.
- R5: `out_valid` equals `in_valid` delayed by the pipeline latency. This is two cycles with the product register and one cycle without it.
- R6: If either operand is zero, the result is zero.
- R7: While `out_valid` is low, `result` keeps its previous value.
- R8: During reset, `out_valid` and `result` are both zero.
- R9: Multiplying by one returns the other operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 16 | First polynomial operand |
| op_b | input | 16 | Second polynomial operand |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 16 | (op_a · op_b) mod P |

## Verification
The bench sweeps every value of `op_a` against a scrambled `op_b`, sweeps every value of `op_b` against an all-ones `op_a`, and runs a full grid of small operands. Together these cover each column of the AND array and each quotient bit of the reduction. A wrong reciprocal bit or a wrong shift amount would leave residues of degree 16 or more, so those results would differ from the bit-serial reference. A dropped term in a column tree would corrupt only the products that reach that column, and the sweeps reach every column. The pure-power case x^8·x^8 exposes a missing fold of the upper half. Gapped streams of `in_valid` exercise latency alignment and value holding. An off-by-one in the valid pipeline, or a result register without an enable, would shift or overwrite outputs.

// File: rtl/gf2_pkg.sv
package gf2_pkg;
  // Default operand width of the CRC-16 flavour of the unit.
  localparam int unsigned CRC_W = 16;
  // Generator polynomial without its implicit x^16 term.
  localparam logic [CRC_W-1:0] CRC16_POLY_LOW = 16'h1021;
  // floor(x^(2*CRC_W-1) / P) over GF(2), used for the quotient estimate.
  localparam logic [CRC_W-1:0] CRC16_RECIP = 16'h8898;
endpackage

// File: rtl/gf2_xor_tree.sv
// Balanced tree of two-input XOR gates over N leaves (heap-ordered nodes).
module gf2_xor_tree #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] leaf_i,
  output logic         sum_o
);
  localparam int unsigned LVL = (N > 1) ? $clog2(N) : 0;
  localparam int unsigned NP  = 1 << LVL;

  logic [2*NP-1:1] node;

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign node[NP+i] = leaf_i[i];
    end else begin : g_pad
      assign node[NP+i] = 1'b0;
    end
  end

  for (genvar n = 1; n < NP; n++) begin : g_node
    assign node[n] = node[2*n] ^ node[2*n+1];
  end

  assign sum_o = node[1];
endmodule

// File: rtl/gf2_clmul.sv
// Carryless multiplier: output bit k is the XOR of a[i]&b[j] over i+j=k.
// Only the low OUT_W bits of the product are built.
module gf2_clmul #(
  parameter int unsigned AW    = 16,
  parameter int unsigned BW    = 16,
  parameter int unsigned OUT_W = AW + BW - 1
) (
  input  logic [AW-1:0]    a_i,
  input  logic [BW-1:0]    b_i,
  output logic [OUT_W-1:0] p_o
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_col
    localparam int LO  = (k > BW - 1) ? k - BW + 1 : 0;
    localparam int HI  = (k < AW - 1) ? k : AW - 1;
    localparam int CNT = HI - LO + 1;

    logic [CNT-1:0] terms;
    for (genvar t = 0; t < CNT; t++) begin : g_term
      assign terms[t] = a_i[LO+t] & b_i[k-LO-t];
    end

    gf2_xor_tree #(.N(CNT)) u_tree (
      .leaf_i (terms),
      .sum_o  (p_o[k])
    );
  end
endmodule

// File: rtl/gf2_barrett_reduce.sv
// Reduces a (2W-1)-bit GF(2) product modulo x^W + POLY_LOW using a
// precomputed reciprocal instead of long division.
module gf2_barrett_reduce #(
  parameter int unsigned   W        = 16,
  parameter logic [W-1:0]  POLY_LOW = 16'h1021,
  parameter logic [W-1:0]  RECIP    = 16'h8898
) (
  input  logic [2*W-2:0] prod_i,
  output logic [W-1:0]   rem_o
);
  localparam int unsigned HW  = W - 1;       // width of the upper part
  localparam int unsigned QPW = HW + W - 1;  // width of upper * reciprocal

  logic [HW-1:0]  upper;
  logic [W-1:0]   lower;
  logic [QPW-1:0] qprod;
  logic [HW-1:0]  quot;
  logic [HW-1:0]  qprod_unused_lo;
  logic [W-1:0]   fold;

  assign upper = prod_i[2*W-2:W];
  assign lower = prod_i[W-1:0];

  // quotient estimate: (upper * RECIP) >> (W-1)
  gf2_clmul #(.AW(HW), .BW(W), .OUT_W(QPW)) u_qmul (
    .a_i (upper),
    .b_i (RECIP),
    .p_o (qprod)
  );
  assign {quot, qprod_unused_lo} = qprod;

  // low W bits of quot * P; the x^W term of P cannot reach them
  gf2_clmul #(.AW(HW), .BW(W), .OUT_W(W)) u_pmul (
    .a_i (quot),
    .b_i (POLY_LOW),
    .p_o (fold)
  );

  assign rem_o = lower ^ fold;
endmodule

// File: rtl/gf2_mulmod.sv
module gf2_mulmod
  import gf2_pkg::*;
#(
  parameter int unsigned  W            = CRC_W,
  parameter logic [W-1:0] POLY_LOW     = CRC16_POLY_LOW,
  parameter logic [W-1:0] RECIP        = CRC16_RECIP,
  parameter bit           PIPE_PRODUCT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int unsigned PW = 2*W - 1;

  // ---------------- reset release synchroniser ----------------
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // ---------------- carryless product ----------------
  logic [PW-1:0] prod_c;
  gf2_clmul #(.AW(W), .BW(W), .OUT_W(PW)) u_mul (
    .a_i (op_a),
    .b_i (op_b),
    .p_o (prod_c)
  );

  logic          red_vld;
  logic [PW-1:0] red_prod;

  if (PIPE_PRODUCT) begin : g_pipe
    logic          s1_vld_q, s1_vld_d;
    logic [PW-1:0] s1_prod_q, s1_prod_d;
    logic          s1_en;

    assign s1_en = in_valid;

    always_comb begin
      s1_vld_d  = in_valid;
      s1_prod_d = s1_en ? prod_c : s1_prod_q;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        s1_vld_q  <= 1'b0;
        s1_prod_q <= '0;
      end else begin
        s1_vld_q  <= s1_vld_d;
        s1_prod_q <= s1_prod_d;
      end
    end

    assign red_vld  = s1_vld_q;
    assign red_prod = s1_prod_q;
  end else begin : g_direct
    assign red_vld  = in_valid;
    assign red_prod = prod_c;
  end

  // ---------------- reduction ----------------
  logic [W-1:0] rem_c;
  gf2_barrett_reduce #(.W(W), .POLY_LOW(POLY_LOW), .RECIP(RECIP)) u_red (
    .prod_i (red_prod),
    .rem_o  (rem_c)
  );

  // ---------------- output register ----------------
  logic         out_vld_q, out_vld_d;
  logic [W-1:0] res_q, res_d;
  logic         res_en;

  assign res_en = red_vld;

  always_comb begin
    out_vld_d = red_vld;
    res_d     = res_en ? rem_c : res_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_vld_q <= 1'b0;
      res_q     <= '0;
    end else begin
      out_vld_q <= out_vld_d;
      res_q     <= res_d;
    end
  end

  assign out_valid = out_vld_q;
  assign result    = res_q;

  // ---------------- assertions ----------------
  // cycles since reset release, saturating; keeps $past inside history
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q != 2'd0 && !out_valid) |-> $stable(result));

  if (PIPE_PRODUCT) begin : g_chk2
    assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (age_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));
    assert_zero_operand_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (age_q >= 2'd2 && out_valid && ($past(op_a, 2) == '0 || $past(op_b, 2) == '0))
      |-> (result == '0));
    assert_identity_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (age_q >= 2'd2 && out_valid && $past(op_a, 2) == W'(1))
      |-> (result == $past(op_b, 2)));
  end else begin : g_chk1
    assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (age_q >= 2'd1) |-> (out_valid == $past(in_valid)));
    assert_zero_operand_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (age_q >= 2'd1 && out_valid && ($past(op_a) == '0 || $past(op_b) == '0))
      |-> (result == '0));
    assert_identity_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (age_q >= 2'd1 && out_valid && $past(op_a) == W'(1))
      |-> (result == $past(op_b)));
  end
endmodule

// File: tb/gf2_mulmod_bench.sv
module gf2_mulmod_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] op_a, op_b;
  logic        out_valid;
  logic [15:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gf2_mulmod u_gf2_mulmod (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
  );

  // Bit-serial reference from R1.
  function automatic logic [15:0] ref_mm(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] p = 16'h0;
    for (int i = 15; i >= 0; i--) begin
      p = p[15] ? ((p << 1) ^ 16'h1021) : (p << 1);
      if (b[i]) p ^= a;
    end
    return p;
  endfunction

  // Plain carryless product for small operands (R2).
  function automatic logic [15:0] clmul_small(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] p = 16'h0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= (a << i);
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  logic [1:0]  hv;
  logic [15:0] hr [2];
  string       ht [2];
  logic [15:0] last_res;

  // One clock: check what was issued two cycles ago (R4), then issue.
  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b,
                      input logic [15:0] exp, input string tg);
    @(negedge clk);
    chk(out_valid == hv[1], "R5", {15'd0, out_valid}, {15'd0, hv[1]});
    if (hv[1]) chk(result == hr[1], ht[1], result, hr[1]);
    else       chk(result == last_res, "R7", result, last_res);
    last_res = result;
    hv[1] = hv[0]; hr[1] = hr[0]; ht[1] = ht[0];
    hv[0] = v;     hr[0] = exp;   ht[0] = tg;
    in_valid = v; op_a = a; op_b = b;
  endtask

  task automatic op(input logic [15:0] a, input logic [15:0] b, input string tg);
    step(1'b1, a, b, ref_mm(a, b), tg);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'hDEAD, 16'hBEEF, 16'h0, "");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    hv = '0; hr[0] = '0; hr[1] = '0; ht[0] = ""; ht[1] = ""; last_res = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", {15'd0, out_valid}, 16'h0);
      chk(result == 16'h0, "R8", result, 16'h0);
    end
    rst_n = 1'b1;
    idle(4);

    // R3: pure power that needs the fold; also check R1 agreement of constant
    begin
      logic [15:0] e = ref_mm(16'h0100, 16'h0100);
      chk(e == 16'h1021, "R3", e, 16'h1021);
      step(1'b1, 16'h0100, 16'h0100, 16'h1021, "R3");
      step(1'b1, 16'h8000, 16'h8000, ref_mm(16'h8000, 16'h8000), "R3");
      step(1'b1, 16'hFFFF, 16'hFFFF, ref_mm(16'hFFFF, 16'hFFFF), "R3");
    end

    // R6 / R9 corners
    op(16'h0000, 16'hFFFF, "R6");
    op(16'hA5A5, 16'h0000, "R6");
    op(16'h0000, 16'h0000, "R6");
    op(16'h0001, 16'hC3D2, "R9");
    op(16'h7E11, 16'h0001, "R9");
    op(16'h0001, 16'h0001, "R9");
    idle(3);

    // R2: grid of small operands, result is the unreduced product
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 7)
        step(1'b1, 16'(a), 16'(b), clmul_small(16'(a), 16'(b)), "R2");
    idle(2);

    // R1 R4: every op_a back to back against a scrambled op_b
    for (int a = 0; a < 65536; a++) begin
      logic [15:0] b = 16'((a * 16'h9E37) ^ (a >> 3) ^ 16'h5A3C);
      op(16'(a), b, "R1 R4");
    end

    // R1: every op_b against all-ones op_a
    for (int b = 0; b < 65536; b++) op(16'hFFFF, 16'(b), "R1");

    // R5 R7: gapped stream
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a = 16'(i * 16'h3B1D + 16'h0101);
      logic [15:0] b = 16'(i * 16'h71C3 + 16'h1F00);
      if ((i % 3) == 1 || (i % 7) == 0) step(1'b0, a, b, 16'h0, "");
      else op(a, b, "R1 R5");
    end
    idle(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule